// File: doc/BRIEF.md
# MDIO Management Transaction Engine

This engine turns a two-register software view into single clause-22 management frames on an external PHY management bus. Software first loads a 16-bit data register, then writes a control word that packs the direction, the PHY address and the register offset. That control write launches exactly one frame on MDC/MDIO. A finished flag in the control word reads 0 while the frame runs and returns to 1 when it ends. Software is expected to poll this flag before and after each access.

MDC is produced from the system clock by a programmable half-period divider and runs only while a frame is in flight. The engine changes MDIO on the falling edge of MDC and samples the PHY's reply on the rising edge. For a read, it releases MDIO from the turnaround onward. When a read completes, the returned 16 bits are placed in the data register.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, the control register reads 16'h8000 (finished flag, bit 15, set), the data register reads 0, MDC is low and MDIO is released (`mdio_oe` = 0).
- R2: The control word places the PHY address in bits 12:8, the register offset in bits 4:0 and the write flag in bit 14 (0 = read). A control write made while finished is accepted. The finished flag reads 0 from the cycle after acceptance. A control read returns the accepted fields in the same positions.
- R3: Each frame is 64 MDC cycles, sent MSB first: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register offset, 2 turnaround bits (10 on a write), then 16 data bits.
- R4: The data bits of a write frame are the contents of the data register at the moment the control word is accepted.
- R5: On a read, `mdio_oe` is 0 from the first turnaround bit through the last data bit. The 16 data bits are sampled from `mdio_in` at MDC rising edges and stored in the data register when the frame ends.
- R6: MDC high and low phases each last max(`mdc_half_div`,1) clock cycles. The finished flag returns to 1 exactly 128·max(`mdc_half_div`,1) cycles after the accepting edge.
- R7: While a frame runs, `mdio_out` never changes at an MDC rising edge.
- R8: A control write made while a frame is in flight is ignored. The running frame, its fields and its completion time are unchanged.
- R9: While idle, MDC stays low and the finished flag stays 1.
- R10: If a software data-register write falls in the same cycle as the end of a read frame, the value returned by the PHY is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select for read and write: 0 control, 1 data |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data of the selected register (combinational) |
| mdc_half_div | input | 8 | MDC half period in clock cycles (0 treated as 1) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_out`; 0 releases the line |
| mdio_in | input | 1 | Management data seen on the line |

## Verification
Two events can land in the same clock cycle: the end of a read frame, which loads the PHY reply into the data register, and a software write to that same register. The bench uses the fixed frame length of 128 half periods to compute the completion edge. It places a data write on exactly that edge, after confirming that the finished flag is still 0 one cycle earlier. The check then requires the finished flag to be 1 and the data register to hold the PHY's reply rather than the software value. A control write issued in the middle of a frame is judged the same way, at the ports: the captured frame bits and the fields read back must belong to the first command only.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    parameter int DATA_W     = 16;
    parameter int PHYAD_W    = 5;
    parameter int REGAD_W    = 5;
    parameter int PRE_BITS   = 32;
    parameter int FRAME_BITS = PRE_BITS + 2 + 2 + PHYAD_W + REGAD_W + 2 + DATA_W;
    parameter int TA_START   = FRAME_BITS - DATA_W - 2;
    parameter int DATA_START = FRAME_BITS - DATA_W;

    parameter int CTL_DONE_BIT = 15;
    parameter int CTL_WR_BIT   = 14;
    parameter int CTL_PHY_LSB  = 8;
    parameter int CTL_REG_LSB  = 0;

    typedef struct packed {
        logic               wr;
        logic [PHYAD_W-1:0] phy;
        logic [REGAD_W-1:0] regad;
    } mgmt_cmd_t;

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_period,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [DIV_W-1:0] limit;
    logic             term;

    always_comb begin
        limit = (half_period == '0) ? DIV_W'(1) : half_period;
        term  = run && (st_q.cnt == limit - DIV_W'(1));
        st_d  = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (term) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc       = st_q.mdc;
    assign rise_tick = term && !st_q.mdc;
    assign fall_tick = term && st_q.mdc;

endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
    import mdio_mgmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_frame,
    input  logic                  load_is_read,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  mdio_in,
    output logic                  mdio_out,
    output logic                  mdio_oe,
    output logic [DATA_W-1:0]     rx_data,
    output logic                  frame_end
);

    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] TA_IDX    = CNT_W'(TA_START);
    localparam logic [CNT_W-1:0] DATA_IDX  = CNT_W'(DATA_START);

    typedef struct packed {
        logic [FRAME_BITS-1:0] sh;
        logic [CNT_W-1:0]      cnt;
        logic                  rd;
        logic                  oe;
        logic                  active;
        logic [DATA_W-1:0]     rx;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         last_bit;
    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        st_d     = st_q;
        last_bit = st_q.active && (st_q.cnt == LAST_IDX);
        next_cnt = st_q.cnt + CNT_W'(1);
        if (load) begin
            st_d.sh     = load_frame;
            st_d.cnt    = '0;
            st_d.rd     = load_is_read;
            st_d.oe     = 1'b1;
            st_d.active = 1'b1;
        end else if (st_q.active) begin
            if (rise_tick && st_q.rd && (st_q.cnt >= DATA_IDX)) begin
                st_d.rx = {st_q.rx[DATA_W-2:0], mdio_in};
            end
            if (fall_tick) begin
                if (last_bit) begin
                    st_d.active = 1'b0;
                    st_d.oe     = 1'b0;
                end else begin
                    st_d.cnt = next_cnt;
                    st_d.sh  = {st_q.sh[FRAME_BITS-2:0], 1'b1};
                    if (st_q.rd && (next_cnt >= TA_IDX)) begin
                        st_d.oe = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdio_out  = st_q.sh[FRAME_BITS-1];
    assign mdio_oe   = st_q.oe;
    assign rx_data   = st_q.rx;
    assign frame_end = fall_tick && last_bit;

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [DIV_W-1:0]  mdc_half_div,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);

    typedef struct packed {
        mgmt_cmd_t         cmd;
        logic [DATA_W-1:0] data;
        logic              busy;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic                  ctl_wr;
    logic                  data_wr;
    logic                  accept;
    mgmt_cmd_t             new_cmd;
    logic [FRAME_BITS-1:0] frame;
    logic                  rise_tick;
    logic                  fall_tick;
    logic [DATA_W-1:0]     rx_data;
    logic                  frame_end;
    logic [DATA_W-1:0]     ctl_view;

    always_comb begin
        ctl_wr        = cfg_we && !cfg_sel;
        data_wr       = cfg_we && cfg_sel;
        accept        = ctl_wr && !st_q.busy;
        new_cmd.wr    = cfg_wdata[CTL_WR_BIT];
        new_cmd.phy   = cfg_wdata[CTL_PHY_LSB +: PHYAD_W];
        new_cmd.regad = cfg_wdata[CTL_REG_LSB +: REGAD_W];

        frame = {{PRE_BITS{1'b1}},
                 2'b01,
                 new_cmd.wr ? 2'b01 : 2'b10,
                 new_cmd.phy,
                 new_cmd.regad,
                 2'b10,
                 new_cmd.wr ? st_q.data : {DATA_W{1'b1}}};

        st_d = st_q;
        if (accept) begin
            st_d.cmd  = new_cmd;
            st_d.busy = 1'b1;
        end
        if (data_wr) begin
            st_d.data = cfg_wdata;
        end
        if (frame_end) begin
            st_d.busy = 1'b0;
            if (!st_q.cmd.wr) begin
                st_d.data = rx_data;
            end
        end

        ctl_view = '0;
        ctl_view[CTL_DONE_BIT]               = !st_q.busy;
        ctl_view[CTL_WR_BIT]                 = st_q.cmd.wr;
        ctl_view[CTL_PHY_LSB +: PHYAD_W]     = st_q.cmd.phy;
        ctl_view[CTL_REG_LSB +: REGAD_W]     = st_q.cmd.regad;
        cfg_rdata = cfg_sel ? st_q.data : ctl_view;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mdio_mdc_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (st_q.busy),
        .half_period (mdc_half_div),
        .mdc         (mdc),
        .rise_tick   (rise_tick),
        .fall_tick   (fall_tick)
    );

    mdio_frame_shift u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (accept),
        .load_frame   (frame),
        .load_is_read (!new_cmd.wr),
        .rise_tick    (rise_tick),
        .fall_tick    (fall_tick),
        .mdio_in      (mdio_in),
        .mdio_out     (mdio_out),
        .mdio_oe      (mdio_oe),
        .rx_data      (rx_data),
        .frame_end    (frame_end)
    );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_wr,
    input logic        busy,
    input logic [10:0] cmd,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe
);

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !busy) |=> busy);                                     // R2

    AST_IDLE_MDC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctl_wr) |=> $stable(mdc));                            // R9

    AST_NO_CHANGE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_out));                               // R7

    AST_BUSY_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && busy) |=> $stable(cmd));                              // R8

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);                                             // R1

endmodule

bind mdio_mgmt_engine mdio_mgmt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .busy     (st_q.busy),
    .cmd      (st_q.cmd),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
);

// File: tb/mdio_mgmt_engine_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [7:0]  mdc_half_div = 8'd1;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_mgmt_engine u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .mdc_half_div (mdc_half_div),
        .mdc          (mdc),
        .mdio_out     (mdio_out),
        .mdio_oe      (mdio_oe),
        .mdio_in      (mdio_in)
    );

    // PHY model: captures rising-edge bits, answers reads on falling edges
    logic        phy_clr = 1'b0;
    int          rcnt;
    logic [63:0] cap;
    logic [63:0] cap_oe;
    logic [15:0] phy_val = 16'h0000;
    logic        mdio_in_r;

    always @(posedge mdc or posedge phy_clr) begin
        if (phy_clr) begin
            rcnt   <= 0;
            cap    <= '0;
            cap_oe <= '0;
        end else begin
            rcnt   <= rcnt + 1;
            cap    <= {cap[62:0], mdio_oe ? mdio_out : 1'b1};
            cap_oe <= {cap_oe[62:0], mdio_oe};
        end
    end

    always @(negedge mdc or posedge phy_clr) begin
        if (phy_clr) mdio_in_r <= 1'b1;
        else if (rcnt >= 48 && rcnt < 64) mdio_in_r <= phy_val[63 - rcnt];
        else mdio_in_r <= 1'b1;
    end
    assign mdio_in = mdio_in_r;

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [15:0] val);
        @(negedge clk);
        cfg_sel = sel;
        #1 val = cfg_rdata;
    endtask

    task automatic clear_phy();
        @(negedge clk); phy_clr = 1'b1;
        #1 phy_clr = 1'b0;
    endtask

    task automatic wait_done();
        logic [15:0] v;
        v = '0;
        for (int i = 0; i < 4000; i++) begin
            rd_reg(1'b0, v);
            if (v[15]) break;
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                              input logic [4:0] ra, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, ra,
                wr ? 2'b10 : 2'b11, wr ? wd : 16'hFFFF};
    endfunction

    function automatic logic [63:0] exp_oe(input logic wr);
        return wr ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
    endfunction

    // {wr, phy, reg, write data, phy reply, half divider}
    localparam logic [50:0] VECS [0:5] = '{
        {1'b1, 5'd1,  5'd0,  16'hA5C3, 16'h0000, 8'd2},
        {1'b0, 5'd31, 5'd31, 16'h0000, 16'h1234, 8'd1},
        {1'b1, 5'd16, 5'd9,  16'h0001, 16'h0000, 8'd0},
        {1'b0, 5'd0,  5'd1,  16'h0000, 16'hFFFE, 8'd3},
        {1'b1, 5'd21, 5'd30, 16'h8000, 16'h0000, 8'd1},
        {1'b0, 5'd10, 5'd5,  16'h0000, 16'h7001, 8'd2}
    };

    initial begin
        #(20 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int t0, t1, t2;
        clear_phy();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(1'b0, v); check(v == 16'h8000, "R1 ctl", 64'(v), 64'h8000);
        rd_reg(1'b1, v); check(v == 16'h0000, "R1 data", 64'(v), 64'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {62'b0, mdc, mdio_oe}, 64'h0);

        // vector table: R2 R3 R4 R5
        for (int k = 0; k < 6; k++) begin
            logic        wr;
            logic [4:0]  phy, ra;
            logic [15:0] wd, pr;
            {wr, phy, ra, wd, pr, mdc_half_div} = VECS[k];
            phy_val = pr;
            clear_phy();
            if (wr) wr_reg(1'b1, wd);
            wr_reg(1'b0, {1'b0, wr, 1'b0, phy, 3'b000, ra});
            rd_reg(1'b0, v);
            check(v[15] == 1'b0, "R2 finished clears", 64'(v), 64'h0);
            wait_done();
            check(cap == exp_frame(wr, phy, ra, wd), "R3 frame bits", cap, exp_frame(wr, phy, ra, wd));
            check(cap_oe == exp_oe(wr), "R5 line release", cap_oe, exp_oe(wr));
            rd_reg(1'b0, v);
            check(v == {1'b1, wr, 1'b0, phy, 3'b000, ra}, "R2 ctl readback", 64'(v),
                  64'({1'b1, wr, 1'b0, phy, 3'b000, ra}));
            rd_reg(1'b1, v);
            check(v == (wr ? wd : pr), wr ? "R4 data kept" : "R5 read data", 64'(v), 64'(wr ? wd : pr));
        end

        // R6 MDC phase lengths with half divider 3
        mdc_half_div = 8'd3;
        clear_phy();
        wr_reg(1'b0, 16'h0102);
        @(posedge mdc); t0 = cyc;
        @(negedge mdc); t1 = cyc;
        @(posedge mdc); t2 = cyc;
        check(t1 - t0 == 3, "R6 high phase", 64'(t1 - t0), 64'd3);
        check(t2 - t0 == 6, "R6 period", 64'(t2 - t0), 64'd6);
        wait_done();

        // R9 idle: MDC quiet, finished sticky
        clear_phy();
        repeat (40) @(negedge clk);
        check(rcnt == 0 && mdc == 1'b0, "R9 idle mdc", 64'(rcnt), 64'd0);
        rd_reg(1'b0, v); check(v[15] == 1'b1, "R9 finished sticky", 64'(v[15]), 64'd1);

        // R8 control write during a frame is ignored
        mdc_half_div = 8'd1;
        phy_val = 16'h0000;
        clear_phy();
        wr_reg(1'b1, 16'h1234);
        wr_reg(1'b0, 16'h4307);
        repeat (5) @(negedge clk);
        wr_reg(1'b0, 16'h0911);
        wait_done();
        check(cap == exp_frame(1'b1, 5'd3, 5'd7, 16'h1234), "R8 frame unchanged", cap,
              exp_frame(1'b1, 5'd3, 5'd7, 16'h1234));
        check(rcnt == 64, "R8 no restart", 64'(rcnt), 64'd64);
        rd_reg(1'b0, v); check(v == 16'hC307, "R8 fields kept", 64'(v), 64'hC307);

        // R6 exact completion edge, R10 data write collides with read end
        mdc_half_div = 8'd2;
        phy_val = 16'hBEEF;
        clear_phy();
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h0405;
        @(posedge clk);
        repeat (255) @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 1'b0;
        #1 check(cfg_rdata[15] == 1'b0, "R6 still busy before last edge", 64'(cfg_rdata[15]), 64'd0);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 16'h5555;
        @(negedge clk);
        cfg_we = 1'b0;
        rd_reg(1'b0, v); check(v[15] == 1'b1, "R6 done at 128 half periods", 64'(v[15]), 64'd1);
        rd_reg(1'b1, v); check(v == 16'hBEEF, "R10 reply wins", 64'(v), 64'hBEEF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule